// File: doc/BRIEF.md
# Keypad Symbol Sequence Detector

This block watches four push buttons that stand for the symbols 1, 2, 3 and 4, plus one init button, and looks for the five-symbol code 4 3 1 2 3. Each raw button passes through a two-flop synchronizer and a level filter. A symbol only counts once its button has stayed high for a set run of clock cycles. Each filtered press then becomes one single-cycle event. A partial-match recognizer follows the incoming symbols and finds the code wherever it starts inside a session. A session is everything entered since the last init press, and it holds at most ten symbols.

The outputs are a 12-bit LED bank and two status flags. The LEDs stay dark while symbols are still being entered. When the code is found, the whole bank blinks on and off at a rate set by a clock divider, and the block stays in that state. When ten symbols have gone in without the code, the block locks: it shows a fixed alternating pattern and ignores symbol buttons. Only init (or reset) returns the block to entry. The block has no data stream, so every pin is a plain level.

Top module: `keypad_seq_detector`

## Requirements
- R1: Bit i of `sym_btn_raw` stands for symbol i+1. A press that is held for any length of time counts as exactly one symbol.
- R2: A raw button (symbol or init) only counts as pressed after it has been sampled high on `DEB_CYCLES` consecutive clock cycles. A shorter high pulse, or a bouncing train of such pulses, has no effect.
- R3: When several symbol presses are accepted in the same cycle, the lowest-numbered symbol is taken and the others are dropped.
- R4: The code 4,3,1,2,3 is recognized wherever it starts inside the session, including overlapped starts such as 4 3 1 4 3 1 2 3 and 4 4 3 1 2 3. A symbol that breaks a partial match, unless it is a 4, sends the recognizer back to the start.
- R5: Once the code is found, `matched` is 1 and `locked` is 0. `led` alternates between all ones for `FLASH_DIV` cycles and all zeros for `FLASH_DIV` cycles, and it takes no other value. Symbol presses are ignored until init.
- R6: After `MAX_SYMS` symbols without a match, `locked` is 1 and `led` holds a pattern in which the most significant bit is on and the bits then alternate downward (0xAAA for 12 bits). Symbol presses are ignored while locked.
- R7: If the symbol that completes the code is also the last one allowed in the session, the result is a match and not a lock.
- R8: An accepted init press returns the block to entry: `matched`=0, `locked`=0, `led`=0, the symbol count at zero and the recognizer at the start.
- R9: After reset and during entry, `led` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_btn_raw | input | 4 | Raw symbol buttons; bit i stands for symbol i+1 |
| init_btn_raw | input | 1 | Raw init button |
| led | output | LED_W | LED bank drive |
| matched | output | 1 | Code found in this session |
| locked | output | 1 | Session budget used up without a match |

## Verification
The bench builds the block with `DEB_CYCLES`=3 and `FLASH_DIV`=5 and keeps the default 12 LEDs and ten-symbol budget. With these values a full press costs only a few cycles, so the bench can run every one of the 1024 five-symbol prefixes, each followed by a derived five-symbol tail. That covers the code at the start, in the middle and at the end of a session, as well as every lock. The short flash period also allows exact measurement of the on and off run lengths. Directed cases add glitches one cycle shorter than the filter window, long holds, and simultaneous presses.

// File: rtl/kseq_pkg.sv
package kseq_pkg;
  localparam int N_SYM    = 4;
  localparam int CODE_LEN = 5;

  // symbol value minus one: 2'd0 is symbol 1, 2'd3 is symbol 4
  typedef logic [1:0] sym_t;

  typedef enum logic [1:0] {
    SES_ENTER = 2'd0,
    SES_MATCH = 2'd1,
    SES_LOCK  = 2'd2
  } ses_e;

  // code 4 3 1 2 3, encoded as value minus one
  function automatic sym_t code_sym(input int unsigned k);
    case (k)
      0:       return 2'd3;
      1:       return 2'd2;
      2:       return 2'd0;
      3:       return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/kseq_btn_filter.sv
module kseq_btn_filter #(
  parameter int DEB_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic press
);
  localparam int RUN_W = $clog2(DEB_CYCLES + 1);

  logic             sync1, sync2;
  logic [RUN_W-1:0] run;
  logic             level, level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      run     <= '0;
      level   <= 1'b0;
      level_d <= 1'b0;
    end else begin
      sync1   <= raw;
      sync2   <= sync1;
      level_d <= level;
      if (!sync2) begin
        run   <= '0;
        level <= 1'b0;
      end else if (run == RUN_W'(DEB_CYCLES - 1)) begin
        level <= 1'b1;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign press = level & ~level_d;
endmodule

// File: rtl/kseq_tracker.sv
module kseq_tracker
  import kseq_pkg::*;
#(
  parameter int MAX_SYMS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic init_go,
  input  logic sym_go,
  input  sym_t sym,
  output ses_e ses
);
  localparam int CNT_W  = $clog2(MAX_SYMS + 1);
  localparam int PROG_W = $clog2(CODE_LEN + 1);

  logic [CNT_W-1:0]  count;
  logic [PROG_W-1:0] prog, prog_nxt;

  // partial-match step; the code's first symbol occurs nowhere else in it,
  // so every fallback lands on state 1 (a 4) or state 0
  always_comb begin
    if (sym == code_sym(int'(prog)))   prog_nxt = prog + 1'b1;
    else if (sym == code_sym(0))       prog_nxt = PROG_W'(1);
    else                               prog_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || init_go) begin
      ses   <= SES_ENTER;
      count <= '0;
      prog  <= '0;
    end else if (ses == SES_ENTER && sym_go) begin
      count <= count + 1'b1;
      prog  <= prog_nxt;
      if (prog_nxt == PROG_W'(CODE_LEN))              ses <= SES_MATCH;
      else if (count == CNT_W'(MAX_SYMS - 1))         ses <= SES_LOCK;
    end
  end
endmodule

// File: rtl/kseq_led_driver.sv
module kseq_led_driver
  import kseq_pkg::*;
#(
  parameter int LED_W     = 12,
  parameter int FLASH_DIV = 12500000
) (
  input  logic             clk,
  input  logic             rst,
  input  ses_e             ses,
  output logic [LED_W-1:0] led
);
  localparam int DIV_W = $clog2(FLASH_DIV + 1);

  logic [DIV_W-1:0] div;
  logic             phase;
  logic [LED_W-1:0] lock_pat;

  for (genvar i = 0; i < LED_W; i++) begin : g_pat
    assign lock_pat[i] = ((LED_W - 1 - i) % 2) == 0;
  end

  always_ff @(posedge clk) begin
    if (rst || ses != SES_MATCH) begin
      div   <= '0;
      phase <= 1'b1;
    end else if (div == DIV_W'(FLASH_DIV - 1)) begin
      div   <= '0;
      phase <= ~phase;
    end else begin
      div <= div + 1'b1;
    end
  end

  always_comb begin
    case (ses)
      SES_MATCH: led = phase ? '1 : '0;
      SES_LOCK:  led = lock_pat;
      default:   led = '0;
    endcase
  end
endmodule

// File: rtl/keypad_seq_detector.sv
module keypad_seq_detector
  import kseq_pkg::*;
#(
  parameter int DEB_CYCLES = 250000,
  parameter int FLASH_DIV  = 12500000,
  parameter int LED_W      = 12,
  parameter int MAX_SYMS   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SYM-1:0] sym_btn_raw,
  input  logic             init_btn_raw,
  output logic [LED_W-1:0] led,
  output logic             matched,
  output logic             locked
);
  localparam int N_BTN = N_SYM + 1;

  logic [N_BTN-1:0] raw_all, press_all;
  logic [N_SYM-1:0] sym_press;
  logic             init_go, sym_go;
  sym_t             sym_val;
  ses_e             ses;

  assign raw_all = {init_btn_raw, sym_btn_raw};

  for (genvar g = 0; g < N_BTN; g++) begin : g_btn
    kseq_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_flt (
      .clk(clk), .rst(rst), .raw(raw_all[g]), .press(press_all[g])
    );
  end

  assign init_go   = press_all[N_SYM];
  assign sym_press = press_all[N_SYM-1:0];

  // lowest-numbered symbol wins
  always_comb begin
    sym_go  = |sym_press;
    sym_val = '0;
    for (int i = N_SYM - 1; i >= 0; i--) begin
      if (sym_press[i]) sym_val = sym_t'(i);
    end
  end

  kseq_tracker #(.MAX_SYMS(MAX_SYMS)) u_trk (
    .clk(clk), .rst(rst), .init_go(init_go), .sym_go(sym_go),
    .sym(sym_val), .ses(ses)
  );

  kseq_led_driver #(.LED_W(LED_W), .FLASH_DIV(FLASH_DIV)) u_led (
    .clk(clk), .rst(rst), .ses(ses), .led(led)
  );

  assign matched = (ses == SES_MATCH);
  assign locked  = (ses == SES_LOCK);
endmodule

// File: rtl/kseq_checker.sv
module kseq_checker #(
  parameter int LED_W      = 12,
  parameter int DEB_CYCLES = 250000
) (
  input logic             clk,
  input logic             rst,
  input logic             init_raw,
  input logic             init_go,
  input logic             matched,
  input logic             locked,
  input logic [LED_W-1:0] led
);
  localparam int RUN_W = $clog2(DEB_CYCLES + 2);

  logic [LED_W-1:0] lock_ref;
  always_comb begin
    lock_ref = '0;
    for (int i = LED_W - 1; i >= 0; i -= 2) lock_ref[i] = 1'b1;
  end

  // independent count of how long the init level has been held after two stages
  logic             d1, d2;
  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) begin
      d1 <= 1'b0; d2 <= 1'b0; run <= '0;
    end else begin
      d1 <= init_raw;
      d2 <= d1;
      if (!d2)                                  run <= '0;
      else if (run != RUN_W'(DEB_CYCLES))       run <= run + 1'b1;
    end
  end

  a_r2_init_filtered: assert property (@(posedge clk) disable iff (rst)
    init_go |-> run >= RUN_W'(DEB_CYCLES));
  a_r5_flash_levels: assert property (@(posedge clk) disable iff (rst)
    matched |-> (led == '1 || led == '0));
  a_r5_match_holds: assert property (@(posedge clk) disable iff (rst)
    (matched && !init_go) |=> matched);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(matched && locked));
  a_r6_lock_pattern: assert property (@(posedge clk) disable iff (rst)
    locked |-> led == lock_ref);
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (locked && !init_go) |=> locked);
  a_r8_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_go |=> (!matched && !locked));
  a_r9_entry_dark: assert property (@(posedge clk) disable iff (rst)
    (!matched && !locked) |-> led == '0);
endmodule

bind keypad_seq_detector kseq_checker #(.LED_W(LED_W), .DEB_CYCLES(DEB_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .init_raw(init_btn_raw), .init_go(init_go),
  .matched(matched), .locked(locked), .led(led)
);

// File: tb/tb_keypad_seq_detector.sv
module tb_keypad_seq_detector;
  localparam int DEB   = 3;
  localparam int DIV   = 5;
  localparam int LW    = 12;
  localparam int MAXS  = 10;
  localparam logic [LW-1:0] LOCKP = 12'hAAA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    sym_raw = '0;
  logic          init_raw = 1'b0;
  logic [LW-1:0] led;
  logic          matched, locked;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  keypad_seq_detector #(.DEB_CYCLES(DEB), .FLASH_DIV(DIV), .LED_W(LW), .MAX_SYMS(MAXS)) dut (
    .clk(clk), .rst(rst), .sym_btn_raw(sym_raw), .init_btn_raw(init_raw),
    .led(led), .matched(matched), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state_is(input string req, input bit m, input bit l, input logic [LW-1:0] e_led);
    chk(matched == m, req, matched, m);
    chk(locked == l, req, locked, l);
    chk(led == e_led, req, led, e_led);
  endtask

  task automatic press_bits(input logic [3:0] b);
    sym_raw = b;
    repeat (DEB + 1) @(negedge clk);
    sym_raw = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic press(input int s);
    press_bits(4'(1 << (s - 1)));
  endtask

  task automatic do_init;
    init_raw = 1'b1;
    repeat (DEB + 1) @(negedge clk);
    init_raw = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic glitch(input int s, input int len);
    sym_raw = 4'(1 << (s - 1));
    repeat (len) @(negedge clk);
    sym_raw = '0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit has_code(input int q[10]);
    for (int j = 0; j <= 5; j++)
      if (q[j] == 4 && q[j+1] == 3 && q[j+2] == 1 && q[j+3] == 2 && q[j+4] == 3) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int q[10];
    int run;
    logic [LW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    state_is("R9 reset", 0, 0, '0);

    // R4 R7: code ends on the tenth symbol of the session
    do_init;
    begin
      int ex[10] = '{2, 4, 1, 2, 3, 4, 3, 1, 2, 3};
      for (int i = 0; i < 10; i++) begin
        press(ex[i]);
        if (i == 8) state_is("R9 entry dark", 0, 0, '0);
      end
    end
    chk(matched == 1 && locked == 0, "R7 tenth completes", {matched, locked}, 2'b10);

    // R8: init clears a match
    do_init;
    state_is("R8 init after match", 0, 0, '0);

    // R4: overlapped starts
    begin
      int ov[8] = '{4, 3, 1, 4, 3, 1, 2, 3};
      foreach (ov[i]) press(ov[i]);
    end
    chk(matched == 1, "R4 overlap 431-4", matched, 1);
    do_init;
    begin
      int ov2[6] = '{4, 4, 3, 1, 2, 3};
      foreach (ov2[i]) press(ov2[i]);
    end
    chk(matched == 1, "R4 double 4", matched, 1);

    // R5: symbols ignored once matched, then exact flash runs
    press(1);
    chk(matched == 1, "R5 symbol ignored in match", matched, 1);
    v = led;
    while (led == v) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      v = led;
      chk(v == '0 || v == '1, "R5 flash level", v, 0);
      run = 0;
      while (led == v && run < 4 * DIV) begin run++; @(negedge clk); end
      chk(run == DIV, "R5 flash run", run, DIV);
    end

    // R6 R8: lock after ten misses, ignored symbols, init unlocks
    do_init;
    for (int i = 0; i < MAXS - 1; i++) press(1);
    state_is("R6 not yet locked", 0, 0, '0);
    press(2);
    state_is("R6 locked", 0, 1, LOCKP);
    begin
      int cd[5] = '{4, 3, 1, 2, 3};
      foreach (cd[i]) press(cd[i]);
    end
    state_is("R6 symbols ignored", 0, 1, LOCKP);
    do_init;
    state_is("R8 init unlocks", 0, 0, '0);

    // R2: short highs and bounce ignored
    press(4); press(3); press(1); press(2);
    glitch(3, DEB - 1);
    chk(matched == 0, "R2 short pulse ignored", matched, 0);
    for (int i = 0; i < 4; i++) begin
      sym_raw = 4'b0100; repeat (DEB - 1) @(negedge clk);
      sym_raw = '0;      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(matched == 0, "R2 bounce ignored", matched, 0);
    press(3);
    chk(matched == 1, "R2 clean press accepted", matched, 1);
    init_raw = 1'b1; repeat (DEB - 1) @(negedge clk); init_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk(matched == 1, "R2 short init ignored", matched, 1);

    // R1: long hold counts once
    do_init;
    sym_raw = 4'b0001;
    repeat (40) @(negedge clk);
    sym_raw = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < MAXS - 2; i++) press(1);
    chk(locked == 0, "R1 long hold one symbol", locked, 0);
    press(1);
    chk(locked == 1, "R1 count reaches limit", locked, 1);

    // R3: simultaneous presses, lowest wins
    do_init;
    press(4); press_bits(4'b1100); press(1); press(2); press(3);
    chk(matched == 1, "R3 3 beats 4", matched, 1);
    do_init;
    press(4); press_bits(4'b1001); press(3); press(1); press(2); press(3);
    chk(matched == 0, "R3 1 beats 4", matched, 0);

    // R4 R6: sweep every five-symbol prefix with a derived tail
    for (int p = 0; p < 1024; p++) begin
      bit hit5;
      bit hit;
      for (int i = 0; i < 5; i++) q[i] = ((p >> (2 * i)) & 3) + 1;
      for (int i = 0; i < 5; i++) q[5 + i] = ((q[i] + i) % 4) + 1;
      hit5 = (q[0] == 4 && q[1] == 3 && q[2] == 1 && q[3] == 2 && q[4] == 3);
      hit  = has_code(q);
      do_init;
      for (int i = 0; i < 5; i++) press(q[i]);
      chk(matched == hit5 && locked == 0, "R4 sweep mid", {matched, locked}, {hit5, 1'b0});
      for (int i = 5; i < 10; i++) press(q[i]);
      chk(matched == hit && locked == !hit, "R6 sweep end", {matched, locked}, {hit, !hit});
      if (!hit) chk(led == LOCKP, "R6 sweep pattern", led, LOCKP);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule